// File: doc/BRIEF.md
# Maskable Burst Address Counter

This block produces the address for one port of a synchronous memory. It holds an address counter and a mask register. The mask register decides which counter bits are free to change. Both registers are loaded from the port's address lines, and both can be read back onto the same lines. A select input chooses which register a command acts on. A reset input and two active-low strobes then pick the operation taken on each rising clock edge: reset, load, readback, increment or hold.

A mask bit of 1 marks a live counter bit, and a 0 freezes that bit. A burst therefore steps only through the live bit positions and wraps inside them. The frozen bits keep whatever value was last loaded. Counter reset also clears only the live bits. An asynchronous active-low reset puts the block in its known starting state. The counter-interrupt flag exists only as an output that reset drives to its idle level.

Top module: `burst_addr_gen`

## Requirements
- R1: When `rst_n` is low, the block acts at once without waiting for a clock edge. It sets `cur_addr` to all zeros, sets the mask to all ones, drives `wrap_irq_n` high and drives `addr_oe` low. `wrap_irq_n` then stays high.
- R2: When `sel_cnt`=1 and `zero_n`=0, the next edge clears every counter bit whose mask bit is 1. Counter bits whose mask bit is 0 keep their value, and `strobe_n` and `step_n` have no effect.
- R3: When `sel_cnt`=1, `zero_n`=1, `strobe_n`=0 and `step_n`=0, the counter takes the value of `addr_in`.
- R4: When `sel_cnt`=1, `zero_n`=1, `strobe_n`=1 and `step_n`=0, the counter advances by one across the bit positions whose mask bit is 1, with carries passing over masked positions. Masked positions are unchanged. When every live bit is 1, the live bits wrap to 0.
- R5: When `sel_cnt`=1, `zero_n`=1, `strobe_n`=1 and `step_n`=1, the counter holds its value.
- R6: When `sel_cnt`=1, `zero_n`=1, `strobe_n`=0 and `step_n`=1, the counter is read back. After the edge, `addr_out` shows the counter value with `addr_oe` high, and the counter does not change.
- R7: When `sel_cnt`=0 and `zero_n`=0, the mask is set to all ones.
- R8: When `sel_cnt`=0, `zero_n`=1, `strobe_n`=0 and `step_n`=0, the mask takes the value of `addr_in`.
- R9: When `sel_cnt`=0, `zero_n`=1, `strobe_n`=0 and `step_n`=1, the mask is read back. After the edge, `addr_out` shows the mask with `addr_oe` high.
- R10: When `sel_cnt`=0, `zero_n`=1 and `strobe_n`=1, the encoding is reserved. Both the counter and the mask stay unchanged, and `addr_oe` stays low.
- R11: `addr_oe` is high only in the clock cycle that follows a readback command. When `addr_oe` is low, `addr_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sel_cnt | input | 1 | 1 selects the counter, 0 selects the mask register |
| zero_n | input | 1 | Active-low reset of the selected register |
| strobe_n | input | 1 | Active-low address strobe (load or readback) |
| step_n | input | 1 | Active-low count enable; high with strobe low means readback |
| addr_in | input | AW | Address lines, input value for loads |
| addr_out | output | AW | Readback value for the address lines |
| addr_oe | output | 1 | Drive enable for the address lines during readback |
| cur_addr | output | AW | Current counter value sent to the memory |
| wrap_irq_n | output | 1 | Counter-interrupt flag, active low; held idle high |

## Verification
Several properties are checked on every clock. After a hold, after the reserved encoding and after a mask readback, the register concerned must not change. An increment must not disturb masked bits. A counter reset must leave no live bit set. The drive enable must track the readback command of the previous cycle exactly. The scenarios are needed to show arithmetic results that a property cannot express. These are the carry passing over masked holes, the wrap of the live field, the load values, the readback data on the address lines, and the asynchronous effect of reset between clock edges.

// File: rtl/bag_pkg.sv
package bag_pkg;
   typedef enum logic [3:0] {
      OP_CNT_CLR,
      OP_CNT_LD,
      OP_CNT_RB,
      OP_CNT_INC,
      OP_CNT_HOLD,
      OP_MSK_RST,
      OP_MSK_LD,
      OP_MSK_RB,
      OP_RSVD
   } bag_op_t;

   function automatic logic is_readback(input bag_op_t op);
      return (op == OP_CNT_RB) || (op == OP_MSK_RB);
   endfunction
endpackage

// File: rtl/bag_decode.sv
module bag_decode
   import bag_pkg::*;
(
   input  logic    sel_cnt,
   input  logic    zero_n,
   input  logic    strobe_n,
   input  logic    step_n,
   output bag_op_t op
);
   always_comb begin
      if (sel_cnt) begin
         if (!zero_n)                 op = OP_CNT_CLR;
         else if (!strobe_n && !step_n) op = OP_CNT_LD;
         else if (!strobe_n)           op = OP_CNT_RB;
         else if (!step_n)             op = OP_CNT_INC;
         else                          op = OP_CNT_HOLD;
      end else begin
         if (!zero_n)                 op = OP_MSK_RST;
         else if (!strobe_n && !step_n) op = OP_MSK_LD;
         else if (!strobe_n)           op = OP_MSK_RB;
         else                          op = OP_RSVD;
      end
   end
endmodule

// File: rtl/bag_mask.sv
module bag_mask
   import bag_pkg::*;
#(
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bag_op_t       op,
   input  logic [AW-1:0] din,
   output logic [AW-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '1;
      end else begin
         case (op)
            OP_MSK_RST: mask <= '1;
            OP_MSK_LD:  mask <= din;
            default:    mask <= mask;
         endcase
      end
   end

   // R10: reserved encoding leaves the mask alone
   p_rsvd_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RSVD) |=> $stable(mask));
   // R7: mask reset ends with every bit live
   p_mask_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MSK_RST) |=> (&mask));
   // R9: mask readback does not disturb the mask
   p_mask_rb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MSK_RB) |=> $stable(mask));
endmodule

// File: rtl/bag_counter.sv
module bag_counter
   import bag_pkg::*;
#(
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bag_op_t       op,
   input  logic [AW-1:0] din,
   input  logic [AW-1:0] mask,
   output logic [AW-1:0] cnt
);
   logic [AW-1:0] frozen;
   logic [AW-1:0] bridged;
   logic [AW-1:0] inc_val;

   // masked positions are forced to 1 so the carry ripples across them
   assign frozen  = cnt & ~mask;
   assign bridged = (cnt | ~mask) + {{(AW-1){1'b0}}, 1'b1};
   assign inc_val = frozen | (bridged & mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         case (op)
            OP_CNT_CLR: cnt <= frozen;
            OP_CNT_LD:  cnt <= din;
            OP_CNT_INC: cnt <= inc_val;
            default:    cnt <= cnt;
         endcase
      end
   end

   // R2: no live bit survives a counter reset
   p_clr_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CNT_CLR) |=> ((cnt & mask) == '0));
   // R4: masked bits keep their value across an increment
   p_inc_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CNT_INC) |=> ((cnt & ~mask) == $past(cnt & ~mask)));
   // R5: hold keeps the counter
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CNT_HOLD) |=> $stable(cnt));
   // R6: readback keeps the counter
   p_rb_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CNT_RB) |=> $stable(cnt));
   // R10: reserved encoding leaves the counter alone
   p_rsvd_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RSVD) |=> $stable(cnt));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import bag_pkg::*;
#(
   parameter int AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_cnt,
   input  logic          zero_n,
   input  logic          strobe_n,
   input  logic          step_n,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out,
   output logic          addr_oe,
   output logic [AW-1:0] cur_addr,
   output logic          wrap_irq_n
);
   localparam int MAX_AW = 32;

   generate
      if (AW < 2 || AW > MAX_AW) begin : g_bad_width
         $error("burst_addr_gen: AW out of range");
      end
   endgenerate

   bag_op_t       op;
   logic [AW-1:0] mask;
   logic [AW-1:0] cnt;
   logic [AW-1:0] rb_data;
   logic          rb_oe;
   logic          irq_n_q;

   bag_decode u_dec (
      .sel_cnt (sel_cnt),
      .zero_n  (zero_n),
      .strobe_n(strobe_n),
      .step_n  (step_n),
      .op      (op)
   );

   bag_mask #(.AW(AW)) u_mask (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (op),
      .din  (addr_in),
      .mask (mask)
   );

   bag_counter #(.AW(AW)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .op   (op),
      .din  (addr_in),
      .mask (mask),
      .cnt  (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rb_oe   <= 1'b0;
         rb_data <= '0;
         irq_n_q <= 1'b1;
      end else begin
         rb_oe   <= is_readback(op);
         rb_data <= (op == OP_MSK_RB) ? mask : cnt;
         irq_n_q <= irq_n_q;
      end
   end

   assign addr_oe    = rb_oe;
   assign addr_out   = rb_oe ? rb_data : '0;
   assign cur_addr   = cnt;
   assign wrap_irq_n = irq_n_q;

   // R11: drive enable follows a readback command by one cycle
   p_oe_after_rb_r11: assert property (@(posedge clk) disable iff (!rst_n)
      is_readback(op) |=> addr_oe);
   p_oe_only_rb_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !is_readback(op) |=> !addr_oe);
   // R1: flag stays idle
   p_irq_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_irq_n);
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
   localparam int AW = 18;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [AW-1:0] ONES = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_cnt = 1'b1;
   logic          zero_n = 1'b1;
   logic          strobe_n = 1'b1;
   logic          step_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] addr_out;
   logic          addr_oe;
   logic [AW-1:0] cur_addr;
   logic          wrap_irq_n;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_gen #(.AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .sel_cnt(sel_cnt), .zero_n(zero_n),
      .strobe_n(strobe_n), .step_n(step_n), .addr_in(addr_in),
      .addr_out(addr_out), .addr_oe(addr_oe), .cur_addr(cur_addr),
      .wrap_irq_n(wrap_irq_n)
   );

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // apply one command for one edge, return at the following falling edge
   task automatic cmd(input logic s, input logic z, input logic st, input logic sp,
                      input logic [AW-1:0] a);
      sel_cnt = s; zero_n = z; strobe_n = st; step_n = sp; addr_in = a;
      @(posedge clk);
      @(negedge clk);
      sel_cnt = 1'b1; zero_n = 1'b1; strobe_n = 1'b1; step_n = 1'b1; addr_in = '0;
   endtask

   task automatic idle();
      cmd(1'b1, 1'b1, 1'b1, 1'b1, '0);
   endtask

   task automatic read_mask(input string req, input logic [AW-1:0] exp);
      cmd(1'b0, 1'b1, 1'b0, 1'b1, '0);
      check({req, " oe"}, {{(AW-1){1'b0}}, addr_oe}, 1);
      check({req, " mask"}, addr_out, exp);
   endtask

   task automatic t_reset();
      check("R1 cur_addr", cur_addr, '0);
      check("R1 irq", {{(AW-1){1'b0}}, wrap_irq_n}, 1);
      check("R1 oe", {{(AW-1){1'b0}}, addr_oe}, 0);
      read_mask("R1", ONES);
      idle();
      check("R11 oe drop", {{(AW-1){1'b0}}, addr_oe}, 0);
      check("R11 out zero", addr_out, '0);
   endtask

   task automatic t_load_inc();
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 18'h12345);
      check("R3 load", cur_addr, 18'h12345);
      for (int i = 0; i < 3; i++) cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 inc full mask", cur_addr, 18'h12348);
      idle(); idle();
      check("R5 hold", cur_addr, 18'h12348);
      cmd(1'b1, 1'b1, 1'b0, 1'b1, 18'h00777);
      check("R6 oe", {{(AW-1){1'b0}}, addr_oe}, 1);
      check("R6 data", addr_out, 18'h12348);
      check("R6 keep", cur_addr, 18'h12348);
      idle();
      check("R11 oe one cycle", {{(AW-1){1'b0}}, addr_oe}, 0);
      cmd(1'b1, 1'b1, 1'b0, 1'b0, ONES);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 full wrap", cur_addr, '0);
   endtask

   task automatic t_mask();
      cmd(1'b0, 1'b1, 1'b0, 1'b0, 18'h0000F);
      read_mask("R8 load", 18'h0000F);
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 18'h2A00E);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 inc low field", cur_addr, 18'h2A00F);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 field wrap", cur_addr, 18'h2A000);
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 18'h2A00B);
      cmd(1'b1, 1'b0, 1'b0, 1'b0, 18'h11111);
      check("R2 clear live only", cur_addr, 18'h2A000);
      cmd(1'b0, 1'b1, 1'b0, 1'b0, 18'h00005);
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 18'h3FFF0);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 hole step1", cur_addr, 18'h3FFF1);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 hole step2", cur_addr, 18'h3FFF4);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 hole step3", cur_addr, 18'h3FFF5);
      cmd(1'b1, 1'b1, 1'b1, 1'b0, '0);
      check("R4 hole wrap", cur_addr, 18'h3FFF0);
   endtask

   task automatic t_reserved();
      cmd(1'b0, 1'b1, 1'b1, 1'b0, 18'h11111);
      check("R10 cnt step low", cur_addr, 18'h3FFF0);
      check("R10 oe", {{(AW-1){1'b0}}, addr_oe}, 0);
      cmd(1'b0, 1'b1, 1'b1, 1'b1, 18'h22222);
      check("R10 cnt step high", cur_addr, 18'h3FFF0);
      read_mask("R10 mask", 18'h00005);
   endtask

   task automatic t_mask_reset();
      cmd(1'b0, 1'b0, 1'b0, 1'b0, 18'h00003);
      read_mask("R7", ONES);
      cmd(1'b1, 1'b0, 1'b1, 1'b1, '0);
      check("R2 clear full mask", cur_addr, '0);
   endtask

   task automatic t_async_reset();
      cmd(1'b1, 1'b1, 1'b0, 1'b0, 18'h0ABCD);
      cmd(1'b0, 1'b1, 1'b0, 1'b0, 18'h000F0);
      cmd(1'b1, 1'b1, 1'b0, 1'b1, '0);
      #1 rst_n = 1'b0;
      #1;
      check("R1 async cnt", cur_addr, '0);
      check("R1 async oe", {{(AW-1){1'b0}}, addr_oe}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      read_mask("R1 async mask", ONES);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_inc();
      t_mask();
      t_reserved();
      t_mask_reset();
      t_async_reset();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end
endmodule